// File: doc/BRIEF.md
# Ternary Majority Danger Detector

This block watches a 3x3 matrix of balanced-ternary sensor cells and raises a registered flee signal when enough of them read negative. A cell whose value is -1 marks a danger cell; the block counts those cells in one sample and compares the count with a threshold held in a small adaptive register.

The threshold adapts to feedback. Each time the block has just fired, the surrounding system may report whether the fire was warranted. A bad report makes the reflex harder to trigger by raising the threshold one step. A good report makes it easier to trigger by lowering the threshold one step. The threshold never leaves the range 1 to 9. It starts at 7, so out of reset the block fires when seven or more cells are negative.

Top module: `ternary_danger_reflex`

## Requirements
- R1: Each cell is a 2-bit code: 2'b11 is -1, 2'b00 is 0, 2'b01 is +1, and the unused code 2'b10 is treated as 0. Only cells holding 2'b11 add to the danger count. Cell i sits in bits [2i+1:2i] of `cellTrits`.
- R2: When `sampleValid` is high at a rising edge, `fleeOut` after that edge is 1 if the danger count is at least the threshold in force before that edge, else 0.
- R3: When `sampleValid` is low at a rising edge, `fleeOut` is 0 after that edge, whatever the cells hold.
- R4: During reset and after it is released, `fleeOut` is 0 and `thresholdOut` is 7.
- R5: At a rising edge where `fleeOut` is 1 and `fbValid` is 1 with `fbBad` = 1, the threshold increases by 1 after that edge.
- R6: At a rising edge where `fleeOut` is 1 and `fbValid` is 1 with `fbBad` = 0, the threshold decreases by 1 after that edge.
- R7: The threshold stays within 1 to 9: bad feedback at 9 leaves it at 9, good feedback at 1 leaves it at 1.
- R8: Feedback presented while `fleeOut` is 0 leaves the threshold unchanged; the threshold changes at no other time than under R5 and R6.
- R9: When a new valid sample and feedback for the previous fire meet at the same edge, the sample is judged against the threshold as it stood before that edge's feedback update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Cells hold a sample to judge this cycle |
| cellTrits | input | 18 | Nine 2-bit balanced-ternary cells, cell 0 in the low bits |
| fbValid | input | 1 | Feedback on the current fire is presented |
| fbBad | input | 1 | Feedback polarity: 1 = fire was wrong, 0 = fire was right |
| fleeOut | output | 1 | Registered flee decision |
| thresholdOut | output | 4 | Current danger-count threshold |

## Verification
The two functions that can land on one edge are the judgement of a fresh sample and the threshold update driven by feedback on the previous fire. The bench provokes this by presenting a valid sample together with feedback while `fleeOut` is high, choosing a danger count equal to the old threshold so that the decision flips if the new threshold were used by mistake. It judges the result by expecting a flee at that count and the stepped threshold one cycle later, from a model that updates its threshold only after computing the decision.

// File: rtl/reflex_pkg.sv
package reflex_pkg;
  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic capture;   // a sample is judged at this edge
    logic raiseThr;  // step threshold up
    logic lowerThr;  // step threshold down
  } thrStrobe_t;
endpackage

// File: rtl/danger_datapath.sv
module danger_datapath
  import reflex_pkg::*;
#(
  parameter int NUM_CELLS = 9,
  parameter int THR_RESET = 7,
  localparam int CNT_W = $clog2(NUM_CELLS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*NUM_CELLS-1:0] cellTrits,
  input  thrStrobe_t             strobe,
  output logic                   fleeQ,
  output logic [CNT_W-1:0]       thrQ
);
  localparam logic [1:0] NEG_CODE = 2'b11;

  logic [NUM_CELLS-1:0] negMask;
  logic [CNT_W-1:0]     dangerCount;

  // One comparator per cell: does this cell hold -1?
  for (genvar gi = 0; gi < NUM_CELLS; gi++) begin : g_cell
    assign negMask[gi] = (cellTrits[2*gi +: 2] == NEG_CODE);
  end

  // Population count of the negative cells
  always_comb begin
    dangerCount = '0;
    for (int i = 0; i < NUM_CELLS; i++) begin
      dangerCount = dangerCount + CNT_W'(negMask[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fleeQ <= 1'b0;
    end else begin
      fleeQ <= strobe.capture && (dangerCount >= thrQ);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thrQ <= CNT_W'(THR_RESET);
    end else if (strobe.raiseThr) begin
      thrQ <= thrQ + 1'b1;
    end else if (strobe.lowerThr) begin
      thrQ <= thrQ - 1'b1;
    end
  end
endmodule

// File: rtl/danger_control.sv
module danger_control
  import reflex_pkg::*;
#(
  parameter int NUM_CELLS = 9,
  parameter int THR_MIN   = 1,
  parameter int THR_MAX   = 9,
  localparam int CNT_W = $clog2(NUM_CELLS + 1)
) (
  input  logic             sampleValid,
  input  logic             fbValid,
  input  logic             fbBad,
  input  logic             fleeQ,
  input  logic [CNT_W-1:0] thrQ,
  output thrStrobe_t       strobe
);
  logic fbOnFire;
  logic atTop;
  logic atBottom;

  assign fbOnFire = fleeQ && fbValid;
  assign atTop    = (thrQ >= CNT_W'(THR_MAX));
  assign atBottom = (thrQ <= CNT_W'(THR_MIN));

  always_comb begin
    strobe          = '0;
    strobe.capture  = sampleValid;
    strobe.raiseThr = fbOnFire && fbBad && !atTop;
    strobe.lowerThr = fbOnFire && !fbBad && !atBottom;
  end
endmodule

// File: rtl/ternary_danger_reflex.sv
module ternary_danger_reflex
  import reflex_pkg::*;
#(
  parameter int NUM_CELLS = 9,
  parameter int THR_RESET = 7,
  parameter int THR_MIN   = 1,
  parameter int THR_MAX   = NUM_CELLS,
  localparam int CNT_W = $clog2(NUM_CELLS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sampleValid,
  input  logic [2*NUM_CELLS-1:0] cellTrits,
  input  logic                   fbValid,
  input  logic                   fbBad,
  output logic                   fleeOut,
  output logic [CNT_W-1:0]       thresholdOut
);
  thrStrobe_t strobe;

  danger_control #(
    .NUM_CELLS(NUM_CELLS),
    .THR_MIN  (THR_MIN),
    .THR_MAX  (THR_MAX)
  ) ctrl_i (
    .sampleValid(sampleValid),
    .fbValid    (fbValid),
    .fbBad      (fbBad),
    .fleeQ      (fleeOut),
    .thrQ       (thresholdOut),
    .strobe     (strobe)
  );

  danger_datapath #(
    .NUM_CELLS(NUM_CELLS),
    .THR_RESET(THR_RESET)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cellTrits(cellTrits),
    .strobe   (strobe),
    .fleeQ    (fleeOut),
    .thrQ     (thresholdOut)
  );
endmodule

// File: rtl/danger_reflex_checker.sv
module danger_reflex_checker #(
  parameter int NUM_CELLS = 9,
  parameter int THR_MIN   = 1,
  parameter int THR_MAX   = 9,
  localparam int CNT_W = $clog2(NUM_CELLS + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sampleValid,
  input logic [2*NUM_CELLS-1:0] cellTrits,
  input logic                   fbValid,
  input logic                   fbBad,
  input logic                   fleeOut,
  input logic [CNT_W-1:0]       thresholdOut
);
  assert_flee_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |=> !fleeOut);

  assert_all_negative_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && cellTrits == {NUM_CELLS{2'b11}}) |=> fleeOut);

  assert_all_zero_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && cellTrits == '0) |=> !fleeOut);

  assert_thr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (thresholdOut >= CNT_W'(THR_MIN)) && (thresholdOut <= CNT_W'(THR_MAX)));

  assert_bad_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fleeOut && fbValid && fbBad && thresholdOut < CNT_W'(THR_MAX))
      |=> thresholdOut == $past(thresholdOut) + 1'b1);

  assert_good_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fleeOut && fbValid && !fbBad && thresholdOut > CNT_W'(THR_MIN))
      |=> thresholdOut == $past(thresholdOut) - 1'b1);

  assert_no_stray_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fleeOut && fbValid) |=> $stable(thresholdOut));
endmodule

bind ternary_danger_reflex danger_reflex_checker #(
  .NUM_CELLS(NUM_CELLS),
  .THR_MIN  (THR_MIN),
  .THR_MAX  (THR_MAX)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sampleValid (sampleValid),
  .cellTrits   (cellTrits),
  .fbValid     (fbValid),
  .fbBad       (fbBad),
  .fleeOut     (fleeOut),
  .thresholdOut(thresholdOut)
);

// File: tb/ternary_danger_reflex_tb_top.sv
`timescale 1ns/1ps
module ternary_danger_reflex_tb_top;
  localparam int NC = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sampleValid;
  logic [2*NC-1:0] cellTrits;
  logic          fbValid;
  logic          fbBad;
  logic          fleeOut;
  logic [3:0]    thresholdOut;

  int testsRun = 0;
  int testsFailed = 0;
  int expThr = 7;
  bit expFlee = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ternary_danger_reflex dut_i (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .cellTrits(cellTrits),
    .fbValid(fbValid), .fbBad(fbBad), .fleeOut(fleeOut), .thresholdOut(thresholdOut)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Danger count from the encoding in R1: only 2'b11 counts
  function automatic int negCount(input logic [2*NC-1:0] t);
    int n = 0;
    for (int i = 0; i < NC; i++) if (t[2*i +: 2] == 2'b11) n++;
    return n;
  endfunction

  // k cells negative, the rest filled with 00/01/10, rotated by v
  function automatic logic [2*NC-1:0] makeTrits(input int k, input int v);
    logic [2*NC-1:0] t;
    for (int i = 0; i < NC; i++) begin
      int p = (i + v) % NC;
      if (p < k) t[2*i +: 2] = 2'b11;
      else case ((i + v) % 3)
        0: t[2*i +: 2] = 2'b00;
        1: t[2*i +: 2] = 2'b01;
        default: t[2*i +: 2] = 2'b10;
      endcase
    end
    return t;
  endfunction

  // One cycle: drive at negedge, judge at the next negedge
  task automatic step(input logic [2*NC-1:0] t, input bit v, input bit fv, input bit fb,
                      input string tag);
    bit newFlee;
    sampleValid = v; cellTrits = t; fbValid = fv; fbBad = fb;
    newFlee = v && (negCount(t) >= expThr);   // old threshold (R9)
    if (expFlee && fv) begin
      if (fb && expThr < 9) expThr++;
      else if (!fb && expThr > 1) expThr--;
    end
    expFlee = newFlee;
    @(negedge clk);
    check(tag, "fleeOut", int'(fleeOut), int'(expFlee));
    check(tag, "thresholdOut", int'(thresholdOut), expThr);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sampleValid = 0; cellTrits = '1; fbValid = 1; fbBad = 1;
    repeat (3) @(negedge clk);
    // R4: reset state with active-looking inputs
    check("R4", "fleeOut in reset", int'(fleeOut), 0);
    check("R4", "thresholdOut in reset", int'(thresholdOut), 7);
    fbValid = 0; fbBad = 0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R4", "fleeOut after reset", int'(fleeOut), 0);
    check("R4", "thresholdOut after reset", int'(thresholdOut), 7);

    // R2: every count with three filler patterns at threshold 7
    for (int v = 0; v < 3; v++)
      for (int k = 0; k <= NC; k++) step(makeTrits(k, v), 1, 0, 0, "R2");

    // R3: all cells negative but not valid
    step('1, 0, 0, 0, "R3");
    // R8: feedback while flee is low is ignored
    step(makeTrits(0, 0), 0, 1, 1, "R8");
    step(makeTrits(0, 0), 0, 1, 0, "R8");

    // R5 and R7: raise to the top and beyond
    step('1, 1, 0, 0, "R5");
    for (int i = 0; i < 5; i++) step('1, 1, 1, 1, "R5_R7");

    // R1: at threshold 9, each cell tries each code with the rest negative
    for (int c = 0; c < NC; c++)
      for (int code = 0; code < 4; code++) begin
        logic [2*NC-1:0] t = '1;
        t[2*c +: 2] = 2'(code);
        step(t, 1, 0, 0, "R1");
      end

    // R6 and R7: lower to the bottom and beyond
    step('1, 1, 0, 0, "R6");
    for (int i = 0; i < 11; i++) step('1, 1, 1, 0, "R6_R7");
    for (int k = 0; k <= NC; k++) step(makeTrits(k, 1), 1, 0, 0, "R7");

    // Threshold sweep: step up by one, then every count
    for (int s = 0; s < 8; s++) begin
      step('1, 1, 1, 1, "R5");
      for (int k = 0; k <= NC; k++) step(makeTrits(k, 2), 1, 0, 0, "R2");
    end

    // R9: sample at count equal to the old threshold meets feedback
    for (int s = 0; s < 4; s++) begin
      step('1, 1, 0, 0, "R9");
      step(makeTrits(expThr, s), 1, 1, 1, "R9");
    end
    step('1, 1, 0, 0, "R9");
    step(makeTrits(expThr - 1, 0), 1, 1, 0, "R9");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule